// File: doc/BRIEF.md
# Sensor Power-State Register Sequencer

This controller moves an image sensor between its power and capture states. It does this by issuing ordered register writes through a simple request/acknowledge register port. An SPI master, which is not part of this block, sits behind that port. A single command selects one of five actions. For each action the block replays a fixed list of address/data writes. For the two capture actions it instead does a read-modify-write that changes only bit 0 of the shared mode register at address 192.

The block keeps its own view of the sensor state. A command that is not legal from that state is refused with an error pulse, and no bus traffic is issued. While an action is running, `busy` is high and new commands are ignored. A one-cycle `done` pulse marks the end of the action.

Top module: `sensor_pwr_sequencer`

## Requirements
- R1: After reset, `state_o` is 0 (OFF), and `busy`, `done`, `cmd_err` and `req_valid` are all low. State codes: OFF=0, STANDBY=1, IDLE=2, CAPTURING=3.
- R2: Command code 1 (power up) is legal from OFF or STANDBY. It writes address/data pairs in this order: 32/0x2003, 64/0x0001, 40/0x0003, 48/0x0001, 112/0x0007. It ends in IDLE.
- R3: Command code 4 (power down) is legal from IDLE. It writes 112/0x0000, 48/0x0000, 40/0x0000, 64/0x0000, then 32/0x2002. It ends in STANDBY.
- R4: Command code 5 (clock off) is legal from STANDBY. It writes 34/0x0000 once and ends in OFF.
- R5: Command code 2 (capture on) is legal from IDLE. It reads address 192, then writes address 192 with the returned value with bit 0 forced to 1 and bits 15..1 unchanged. It ends in CAPTURING.
- R6: Command code 3 (capture off) is legal from CAPTURING. It reads address 192, then writes address 192 with bit 0 cleared and bits 15..1 unchanged. It ends in IDLE.
- R7: While `req_valid` is high and `req_ack` is low, `req_addr`, `req_wdata` and `req_write` stay stable. The next request appears only after an acknowledge. After an acknowledged read, the block waits for `rsp_valid` before it issues the write.
- R8: `busy` rises in the cycle after a command is accepted. After the final acknowledge, `done` is high for exactly one cycle. In that same cycle `busy` is low and `state_o` shows the new state. `state_o` changes at no other time.
- R9: A command with `busy` low that is illegal from the current state is refused. This includes codes 0, 6 and 7. `cmd_err` is high for one cycle, in the cycle after the command. No request is issued and `state_o` does not change.
- R10: A command presented while `busy` is high is ignored. It raises no `cmd_err`, and it changes neither the write list in progress nor the final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Action code (1..5) |
| busy | output | 1 | Action in progress |
| done | output | 1 | One-cycle end-of-action pulse |
| cmd_err | output | 1 | One-cycle refused-command pulse |
| state_o | output | 2 | Tracked sensor state |
| req_valid | output | 1 | Register request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 9 | Register address |
| req_wdata | output | 16 | Write data |
| req_ack | input | 1 | Request accepted by the serial side |
| rsp_valid | input | 1 | Read data valid |
| rsp_rdata | input | 16 | Read data |

## Verification
The bench loads the mode register with varied bit patterns before each capture command. A design that wrote a constant, or dropped the upper mode bits, would show a wrong write value at address 192. Acknowledges and read responses arrive after random delays, so a design that advanced without an acknowledge, or wrote before the read data arrived, would produce out-of-order or wrong entries in the write log. Illegal codes are tried from every state, and a second command is injected mid-action. A design that checked legality against the wrong state, or latched a command while busy, would either emit traffic or end in the wrong state.

// File: rtl/sensor_pwr_seq_pkg.sv
package sensor_pwr_seq_pkg;

    localparam int ADDR_W     = 9;
    localparam int DATA_W     = 16;
    localparam int CMD_W      = 3;
    localparam int IDX_W      = 3;
    localparam int MODE_BIT   = 0;
    localparam logic [ADDR_W-1:0] MODE_REG  = 9'd192;
    localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'(1) << MODE_BIT;

    localparam logic [CMD_W-1:0] CMD_POWER_UP    = 3'd1;
    localparam logic [CMD_W-1:0] CMD_CAPTURE_ON  = 3'd2;
    localparam logic [CMD_W-1:0] CMD_CAPTURE_OFF = 3'd3;
    localparam logic [CMD_W-1:0] CMD_POWER_DOWN  = 3'd4;
    localparam logic [CMD_W-1:0] CMD_CLOCK_OFF   = 3'd5;

    typedef enum logic [1:0] {
        PS_OFF     = 2'd0,
        PS_STANDBY = 2'd1,
        PS_IDLE    = 2'd2,
        PS_CAPTURE = 2'd3
    } pwr_state_t;

    typedef enum logic [1:0] {
        OP_WRITE,
        OP_READ,
        OP_MODIFY
    } op_kind_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_RSP
    } seq_phase_t;

    typedef struct packed {
        op_kind_t              kind;
        logic                  last;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     data;
    } step_t;

    function automatic step_t mk(op_kind_t k, logic l, logic [ADDR_W-1:0] a,
                                 logic [DATA_W-1:0] d);
        step_t s;
        s.kind = k;
        s.last = l;
        s.addr = a;
        s.data = d;
        return s;
    endfunction

    // Ordered write lists; shut-down replays the bring-up blocks in reverse.
    function automatic step_t step_lookup(logic [CMD_W-1:0] cmd, logic [IDX_W-1:0] idx);
        step_t s;
        s = mk(OP_WRITE, 1'b1, '0, '0);
        case (cmd)
            CMD_POWER_UP: begin
                case (idx)
                    3'd0:    s = mk(OP_WRITE, 1'b0, 9'd32,  16'h2003);
                    3'd1:    s = mk(OP_WRITE, 1'b0, 9'd64,  16'h0001);
                    3'd2:    s = mk(OP_WRITE, 1'b0, 9'd40,  16'h0003);
                    3'd3:    s = mk(OP_WRITE, 1'b0, 9'd48,  16'h0001);
                    default: s = mk(OP_WRITE, 1'b1, 9'd112, 16'h0007);
                endcase
            end
            CMD_POWER_DOWN: begin
                case (idx)
                    3'd0:    s = mk(OP_WRITE, 1'b0, 9'd112, 16'h0000);
                    3'd1:    s = mk(OP_WRITE, 1'b0, 9'd48,  16'h0000);
                    3'd2:    s = mk(OP_WRITE, 1'b0, 9'd40,  16'h0000);
                    3'd3:    s = mk(OP_WRITE, 1'b0, 9'd64,  16'h0000);
                    default: s = mk(OP_WRITE, 1'b1, 9'd32,  16'h2002);
                endcase
            end
            CMD_CLOCK_OFF:
                s = mk(OP_WRITE, 1'b1, 9'd34, 16'h0000);
            CMD_CAPTURE_ON:
                s = (idx == 3'd0) ? mk(OP_READ, 1'b0, MODE_REG, '0)
                                  : mk(OP_MODIFY, 1'b1, MODE_REG, MODE_MASK);
            CMD_CAPTURE_OFF:
                s = (idx == 3'd0) ? mk(OP_READ, 1'b0, MODE_REG, '0)
                                  : mk(OP_MODIFY, 1'b1, MODE_REG, '0);
            default: ;
        endcase
        return s;
    endfunction

    function automatic logic cmd_legal(pwr_state_t st, logic [CMD_W-1:0] cmd);
        case (cmd)
            CMD_POWER_UP:    return (st == PS_OFF) || (st == PS_STANDBY);
            CMD_CAPTURE_ON:  return st == PS_IDLE;
            CMD_CAPTURE_OFF: return st == PS_CAPTURE;
            CMD_POWER_DOWN:  return st == PS_IDLE;
            CMD_CLOCK_OFF:   return st == PS_STANDBY;
            default:         return 1'b0;
        endcase
    endfunction

    function automatic pwr_state_t cmd_target(logic [CMD_W-1:0] cmd);
        case (cmd)
            CMD_POWER_UP:    return PS_IDLE;
            CMD_CAPTURE_ON:  return PS_CAPTURE;
            CMD_CAPTURE_OFF: return PS_IDLE;
            CMD_POWER_DOWN:  return PS_STANDBY;
            default:         return PS_OFF;
        endcase
    endfunction

endpackage

// File: rtl/sensor_pwr_tracker.sv
module sensor_pwr_tracker
    import sensor_pwr_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             busy,
    input  logic             finish,
    output logic             start,
    output logic             cmd_err,
    output pwr_state_t       state_q
);
    pwr_state_t target_q;
    logic       err_q;
    logic       legal;

    always_comb begin
        legal = cmd_legal(state_q, cmd_code);
        start = cmd_valid && !busy && legal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PS_OFF;
            target_q <= PS_OFF;
            err_q    <= 1'b0;
        end else begin
            err_q <= cmd_valid && !busy && !legal;
            if (start)
                target_q <= cmd_target(cmd_code);
            if (finish)
                state_q <= target_q;
        end
    end

    assign cmd_err = err_q;
endmodule

// File: rtl/sensor_pwr_stepper.sv
module sensor_pwr_stepper
    import sensor_pwr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CMD_W-1:0]  start_cmd,
    input  logic              req_ack,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              finish,
    output logic              done
);
    seq_phase_t        phase_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] rd_q;
    logic              done_q;
    step_t             entry;

    always_comb begin
        entry     = step_lookup(cmd_q, idx_q);
        req_valid = (phase_q == SQ_REQ);
        req_write = (entry.kind != OP_READ);
        req_addr  = entry.addr;
        req_wdata = (entry.kind == OP_MODIFY) ? ((rd_q & ~MODE_MASK) | (entry.data & MODE_MASK))
                                              : entry.data;
        finish    = req_valid && req_ack && (entry.kind != OP_READ) && entry.last;
        busy      = (phase_q != SQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= SQ_IDLE;
            cmd_q   <= '0;
            idx_q   <= '0;
            rd_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                SQ_IDLE: begin
                    if (start) begin
                        cmd_q   <= start_cmd;
                        idx_q   <= '0;
                        phase_q <= SQ_REQ;
                    end
                end
                SQ_REQ: begin
                    if (req_ack) begin
                        if (entry.kind == OP_READ) begin
                            phase_q <= SQ_RSP;
                        end else if (entry.last) begin
                            phase_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                SQ_RSP: begin
                    if (rsp_valid) begin
                        rd_q    <= rsp_rdata;
                        idx_q   <= idx_q + 1'b1;
                        phase_q <= SQ_REQ;
                    end
                end
                default: phase_q <= SQ_IDLE;
            endcase
        end
    end

    assign done = done_q;
endmodule

// File: rtl/sensor_pwr_sequencer.sv
module sensor_pwr_sequencer
    import sensor_pwr_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_code,
    output logic        busy,
    output logic        done,
    output logic        cmd_err,
    output logic [1:0]  state_o,
    output logic        req_valid,
    output logic        req_write,
    output logic [8:0]  req_addr,
    output logic [15:0] req_wdata,
    input  logic        req_ack,
    input  logic        rsp_valid,
    input  logic [15:0] rsp_rdata
);
    logic       start;
    logic       finish;
    pwr_state_t state_q;

    sensor_pwr_tracker u_tracker (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .busy      (busy),
        .finish    (finish),
        .start     (start),
        .cmd_err   (cmd_err),
        .state_q   (state_q)
    );

    sensor_pwr_stepper u_stepper (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_cmd (cmd_code),
        .req_ack   (req_ack),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .busy      (busy),
        .finish    (finish),
        .done      (done)
    );

    assign state_o = state_q;
endmodule

// File: rtl/sensor_pwr_sequencer_chk.sv
module sensor_pwr_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        cmd_err,
    input logic [1:0]  state_o,
    input logic        req_valid,
    input logic        req_write,
    input logic [8:0]  req_addr,
    input logic [15:0] req_wdata,
    input logic        req_ack
);
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) &&
                                     $stable(req_wdata) && $stable(req_write)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_req_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> busy);

    p_state_on_done_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(state_o) |-> done);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (!busy && !req_valid && $stable(state_o)));
endmodule

bind sensor_pwr_sequencer sensor_pwr_sequencer_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .cmd_err   (cmd_err),
    .state_o   (state_o),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ack   (req_ack)
);

// File: tb/sensor_pwr_sequencer_tb_top.sv
module sensor_pwr_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic        busy, done, cmd_err, req_valid, req_write;
    logic [1:0]  state_o;
    logic [8:0]  req_addr;
    logic [15:0] req_wdata;
    logic        req_ack = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_rdata = 16'h0;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] reg192 = 16'hA5C2;
    int          log_n = 0;
    logic [8:0]  log_addr [8];
    logic [15:0] log_data [8];
    logic        log_wr   [8];
    int          slow = 0;
    int          bm_state = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sensor_pwr_sequencer dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .busy(busy), .done(done), .cmd_err(cmd_err), .state_o(state_o),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // ---- bench model of the requirements ----
    function automatic bit m_legal(int st, int code);
        case (code)
            1: return st == 0 || st == 1;   // R2
            2: return st == 2;              // R5
            3: return st == 3;              // R6
            4: return st == 2;              // R3
            5: return st == 1;              // R4
            default: return 0;              // R9
        endcase
    endfunction

    function automatic int m_target(int code);
        case (code)
            1: return 2;
            2: return 3;
            3: return 2;
            4: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int m_len(int code);
        case (code)
            1, 4: return 5;
            2, 3: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int m_addr(int code, int i);
        int up [5] = '{32, 64, 40, 48, 112};
        if (code == 1) return up[i];
        if (code == 4) return up[4 - i];
        if (code == 5) return 34;
        return 192;
    endfunction

    function automatic int m_data(int code, int i, logic [15:0] r);
        if (code == 1) begin
            case (i) 0: return 16'h2003; 2: return 16'h0003; 4: return 16'h0007; default: return 16'h0001; endcase
        end
        if (code == 4) return (i == 4) ? 16'h2002 : 16'h0000;
        if (code == 5) return 0;
        if (i == 0) return 0;
        return (code == 2) ? int'({r[15:1], 1'b1}) : int'({r[15:1], 1'b0});
    endfunction

    function automatic string m_tag(int code);
        case (code)
            1: return "R2"; 2: return "R5"; 3: return "R6"; 4: return "R3"; default: return "R4";
        endcase
    endfunction

    // ---- serial-side responder with random delays ----
    initial begin : responder
        int wait_c = 0;
        int rsp_wait = 0;
        bit rsp_pend = 0;
        bit moved = 0;
        bit seen = 0;
        logic [8:0]  h_addr;
        logic [15:0] h_data;
        logic        h_wr;
        forever begin
            @(negedge clk);
            req_ack = 1'b0;
            rsp_valid = 1'b0;
            if (rst) begin
                seen = 0; rsp_pend = 0;
            end else if (rsp_pend) begin
                if (rsp_wait == 0) begin
                    rsp_valid = 1'b1; rsp_rdata = reg192; rsp_pend = 0;
                end else rsp_wait--;
            end else if (req_valid) begin
                if (!seen) begin
                    seen = 1; moved = 0; h_addr = req_addr; h_data = req_wdata; h_wr = req_write;
                end else if (req_addr != h_addr || req_wdata != h_data || req_write != h_wr) moved = 1;
                if (wait_c == 0) begin
                    req_ack = 1'b1;
                    chk(!moved, "R7", "request changed before ack", int'(req_addr), int'(h_addr));
                    if (log_n < 8) begin
                        log_addr[log_n] = req_addr; log_data[log_n] = req_wdata; log_wr[log_n] = req_write;
                    end
                    log_n++;
                    if (req_write && req_addr == 9'd192) reg192 = req_wdata;
                    if (!req_write) begin rsp_pend = 1; rsp_wait = $urandom_range(0, 3); end
                    wait_c = slow + $urandom_range(0, 3);
                    seen = 0;
                end else wait_c--;
            end
        end
    end

    task automatic do_cmd(input int code, input bit intrude);
        int cyc;
        bit legal;
        logic [15:0] r_before;
        while (busy) @(negedge clk);
        log_n = 0;
        r_before = reg192;
        legal = m_legal(bm_state, code);
        cmd_valid = 1'b1; cmd_code = 3'(code);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (legal) begin
            chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
            if (intrude) begin
                cmd_valid = 1'b1; cmd_code = 3'd4;
                @(negedge clk);
                cmd_valid = 1'b0;
                chk(done == 1'b0 && busy == 1'b1, "R10", "still busy at intrusion", busy, 1);
                @(negedge clk);
                chk(cmd_err == 1'b0, "R10", "err on command while busy", cmd_err, 0);
            end
            cyc = 0;
            while (!done && cyc < 300) begin @(negedge clk); cyc++; end
            chk(done == 1'b1, "R8", "done pulse", done, 1);
            chk(busy == 1'b0, "R8", "busy low with done", busy, 0);
            chk(int'(state_o) == m_target(code), m_tag(code), "state after action",
                state_o, m_target(code));
            chk(log_n == m_len(code), m_tag(code), "number of requests", log_n, m_len(code));
            for (int i = 0; i < m_len(code) && i < log_n; i++) begin
                bit exp_wr = !((code == 2 || code == 3) && i == 0);
                chk(int'(log_addr[i]) == m_addr(code, i), m_tag(code), "address",
                    log_addr[i], m_addr(code, i));
                chk(log_wr[i] == exp_wr, m_tag(code), "write flag", log_wr[i], exp_wr);
                if (exp_wr)
                    chk(int'(log_data[i]) == m_data(code, i, r_before), m_tag(code), "data",
                        log_data[i], m_data(code, i, r_before));
            end
            @(negedge clk);
            chk(done == 1'b0, "R8", "done lasts one cycle", done, 0);
            bm_state = m_target(code);
        end else begin
            chk(cmd_err == 1'b1, "R9", "err pulse", cmd_err, 1);
            chk(busy == 1'b0, "R9", "busy on refused", busy, 0);
            @(negedge clk);
            chk(cmd_err == 1'b0, "R9", "err lasts one cycle", cmd_err, 0);
            repeat (3) @(negedge clk);
            chk(log_n == 0, "R9", "traffic on refused", log_n, 0);
            chk(int'(state_o) == bm_state, "R9", "state on refused", state_o, bm_state);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stimulus
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(state_o == 2'd0, "R1", "reset state", state_o, 0);
        chk(!busy && !done && !cmd_err && !req_valid, "R1", "reset outputs",
            {busy, done, cmd_err, req_valid}, 0);

        do_cmd(2, 0);          // capture on from OFF: refused
        do_cmd(0, 0);          // code 0
        do_cmd(7, 0);          // code 7
        do_cmd(4, 0);          // power down from OFF
        slow = 3;
        do_cmd(1, 1);          // power up with a command injected while busy (R10)
        slow = 0;
        reg192 = 16'hA5C2;
        do_cmd(2, 0);          // R5: bit 0 set, 0xA5C3 expected
        chk(reg192 == 16'hA5C3, "R5", "mode register after set", reg192, 16'hA5C3);
        do_cmd(2, 0);          // refused from CAPTURING
        reg192 = 16'h5A3D;
        do_cmd(3, 0);          // R6: bit 0 cleared
        chk(reg192 == 16'h5A3C, "R6", "mode register after clear", reg192, 16'h5A3C);
        do_cmd(6, 0);
        do_cmd(4, 0);          // R3
        do_cmd(4, 0);          // refused from STANDBY
        do_cmd(5, 0);          // R4
        do_cmd(5, 0);          // refused from OFF

        for (int k = 0; k < 80; k++) begin
            int code = $urandom_range(0, 7);
            if (m_legal(bm_state, code) == 0 && $urandom_range(0, 1) == 1)
                code = (bm_state == 0) ? 1 : (bm_state == 1) ? 5 : (bm_state == 2) ? 2 : 3;
            reg192 = 16'($urandom);
            do_cmd(code, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule